// File: doc/BRIEF.md
# Falling-Edge DMA Request Acceptor

This block accepts DMA requests for a single channel from an active-low request pin. Each falling edge on the pin yields exactly one single-operand transfer. The pin passes through a synchronizer. While acceptance is open, a low sample latches a held request. The held request waits for the next bus break. At that point it is cleared and a one-cycle activation pulse launches the transfer.

A small sequencer inside the block runs each transfer in three phases: a source read, a destination write and a one-cycle bus release. Acceptance does not come back just because the pin is low. The pin must have been seen high after activation, and the write phase must be finished. Only then does the block look for a low level again. A pin that stays low therefore gives one transfer, not a stream of them.

Acceptance opens one cycle after a channel-enable pulse. It closes again on transfer end or on a disable pulse.

Top module: `dma_edge_req_acceptor`

## Requirements
- R1: While rst_ni is low, and until the first enable pulse afterwards, req_held_o, activate_o, accept_rdy_o, bus_rd_o, bus_wr_o and bus_rel_o are all 0.
- R2: Before an enable pulse the pin is ignored: a low pin sets neither req_held_o nor accept_rdy_o. accept_rdy_o becomes 1 on the edge that registers the chan_on_i pulse. The pin is first sampled on the edge after that one.
- R3: dreq_ni passes through a two-flop synchronizer. A synchronized low sample taken while accept_rdy_o is 1 sets req_held_o and clears accept_rdy_o on the same edge. req_held_o and accept_rdy_o are never both 1.
- R4: A held request stays held while bus_break_i is 0. On the first edge with bus_break_i at 1 and the sequencer idle, req_held_o goes to 0 and activate_o goes to 1 for exactly one cycle.
- R5: The sequencer behaves as follows:
  - When activate_o is 1, bus_rd_o is 1.
  - bus_rd_o stays 1 until the edge that samples rd_done_i, and bus_wr_o then stays 1 until the edge that samples wr_done_i.
  - bus_rel_o is then 1 for one cycle, after which all three are 0.
  - At most one of the three is 1 at any time.
- R6: accept_rdy_o is 0 whenever bus_rd_o or bus_wr_o is 1. A low-high-low toggle during the write phase re-opens acceptance only after the write phase has ended.
- R7: After a transfer, acceptance re-opens only once a synchronized high sample has been taken since activation. A pin held low throughout gives no second activation. After the pin rises, accept_rdy_o returns to 1 within 4 cycles.
- R8: accept_rdy_o is 0 in the cycle of activate_o and in the two cycles after it.
- R9: A pulse on xfer_end_i or chan_off_i clears req_held_o and accept_rdy_o and returns the sequencer to idle on the next edge. No request is then accepted until a later chan_on_i pulse. An end or disable pulse wins over a simultaneous chan_on_i.
- R10: Each held request produces exactly one activate_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_on_i | input | 1 | One-cycle pulse: channel enable written |
| chan_off_i | input | 1 | One-cycle pulse: channel disabled |
| dreq_ni | input | 1 | DMA request pin, active low, asynchronous |
| bus_break_i | input | 1 | Bus break: the bus may be taken this cycle |
| xfer_end_i | input | 1 | Transfer end condition reached |
| rd_done_i | input | 1 | Source read cycle completes this cycle |
| wr_done_i | input | 1 | Destination write cycle completes this cycle |
| req_held_o | output | 1 | A request is held and waiting for a bus break |
| activate_o | output | 1 | One-cycle pulse: transfer started |
| accept_rdy_o | output | 1 | Acceptance open: a low sample would be held |
| bus_rd_o | output | 1 | Sequencer in the source read phase |
| bus_wr_o | output | 1 | Sequencer in the destination write phase |
| bus_rel_o | output | 1 | Sequencer in the bus release cycle |

## Verification
Some properties are checked by the assertions on every cycle:
- the exclusivity of the held flag and acceptance;
- acceptance staying closed through read and write and for the two cycles after activation;
- activation depending on a bus break and landing in the read phase;
- the one-hot phase outputs;
- the clean return to idle after an end pulse.

Other behaviour can only be shown by the bench's scenarios, because it depends on pin history across a whole transfer:
- exactly one activation per edge, counted under varying read and write latencies;
- a pin held low producing no repeat activation;
- a toggle inside the write phase re-arming only after the write;
- the exact cycle in which sampling begins after an enable pulse.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_READ    = 2'd1,
    SEQ_WRITE   = 2'd2,
    SEQ_RELEASE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[g] <= RST_VAL;
        else         ff_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[g] <= RST_VAL;
        else         ff_q[g] <= ff_q[g-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/dreq_arm.sv
module dreq_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_wr_i,
  input  logic kill_i,
  input  logic pin_low_i,
  input  logic bus_break_i,
  input  logic seq_idle_i,
  input  logic post_write_i,
  output logic held_o,
  output logic rdy_o,
  output logic start_o,
  output logic act_o
);
  logic enabled_q, rdy_q, held_q, wait_q, high_q, act_q;

  assign start_o = held_q & bus_break_i & seq_idle_i & ~kill_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enabled_q <= 1'b0;
      rdy_q     <= 1'b0;
      held_q    <= 1'b0;
      wait_q    <= 1'b0;
      high_q    <= 1'b0;
      act_q     <= 1'b0;
    end else if (kill_i) begin
      enabled_q <= 1'b0;
      rdy_q     <= 1'b0;
      held_q    <= 1'b0;
      wait_q    <= 1'b0;
      high_q    <= 1'b0;
      act_q     <= 1'b0;
    end else begin
      act_q <= start_o;
      if (en_wr_i && !enabled_q) begin
        enabled_q <= 1'b1;
        rdy_q     <= 1'b1;
      end else if (enabled_q) begin
        if (rdy_q && pin_low_i) begin
          held_q <= 1'b1;
          rdy_q  <= 1'b0;
        end
        if (start_o) begin
          held_q <= 1'b0;
          wait_q <= 1'b1;
          high_q <= 1'b0;
        end else if (wait_q) begin
          // high seen during transfer arms the next edge
          if (!pin_low_i) high_q <= 1'b1;
          if (post_write_i && high_q) begin
            wait_q <= 1'b0;
            high_q <= 1'b0;
            rdy_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign held_o = held_q;
  assign rdy_o  = rdy_q;
  assign act_o  = act_q;
endmodule

// File: rtl/dreq_xfer_seq.sv
module dreq_xfer_seq
  import dreq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic       rd_done_i,
  input  logic       wr_done_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:    if (start_i)   state_d = SEQ_READ;
      SEQ_READ:    if (rd_done_i) state_d = SEQ_WRITE;
      SEQ_WRITE:   if (wr_done_i) state_d = SEQ_RELEASE;
      SEQ_RELEASE:                state_d = SEQ_IDLE;
      default:                    state_d = SEQ_IDLE;
    endcase
    if (abort_i) state_d = SEQ_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dma_edge_req_acceptor.sv
module dma_edge_req_acceptor
  import dreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chan_on_i,
  input  logic chan_off_i,
  input  logic dreq_ni,
  input  logic bus_break_i,
  input  logic xfer_end_i,
  input  logic rd_done_i,
  input  logic wr_done_i,
  output logic req_held_o,
  output logic activate_o,
  output logic accept_rdy_o,
  output logic bus_rd_o,
  output logic bus_wr_o,
  output logic bus_rel_o
);
  logic       dreq_s;
  logic       kill;
  logic       start;
  seq_state_e state;

  assign kill = xfer_end_i | chan_off_i;

  dreq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dreq_ni),
    .q_o   (dreq_s)
  );

  dreq_arm u_arm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_wr_i     (chan_on_i),
    .kill_i      (kill),
    .pin_low_i   (~dreq_s),
    .bus_break_i (bus_break_i),
    .seq_idle_i  (state == SEQ_IDLE),
    .post_write_i((state == SEQ_RELEASE) || (state == SEQ_IDLE)),
    .held_o      (req_held_o),
    .rdy_o       (accept_rdy_o),
    .start_o     (start),
    .act_o       (activate_o)
  );

  dreq_xfer_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .abort_i  (kill),
    .rd_done_i(rd_done_i),
    .wr_done_i(wr_done_i),
    .state_o  (state)
  );

  assign bus_rd_o  = (state == SEQ_READ);
  assign bus_wr_o  = (state == SEQ_WRITE);
  assign bus_rel_o = (state == SEQ_RELEASE);
endmodule

// File: rtl/dreq_acceptor_chk.sv
module dreq_acceptor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic chan_off_i,
  input logic bus_break_i,
  input logic xfer_end_i,
  input logic req_held_o,
  input logic activate_o,
  input logic accept_rdy_o,
  input logic bus_rd_o,
  input logic bus_wr_o,
  input logic bus_rel_o
);
  AST_HOLD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_held_o |-> !accept_rdy_o); // R3

  AST_ACT_NEEDS_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activate_o |-> ($past(bus_break_i) && !req_held_o)); // R4

  AST_ACT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activate_o |=> !activate_o); // R10

  AST_ACT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activate_o |-> bus_rd_o); // R5

  AST_PHASE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_rd_o, bus_wr_o, bus_rel_o})); // R5

  AST_REL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rel_o |=> !bus_rel_o && !bus_rd_o && !bus_wr_o); // R5

  AST_NO_RDY_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) |-> !accept_rdy_o); // R6

  AST_CLEAR_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni || xfer_end_i || chan_off_i)
    activate_o |-> !accept_rdy_o ##1 !accept_rdy_o ##1 !accept_rdy_o); // R8

  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_end_i || chan_off_i) |=> !accept_rdy_o && !req_held_o && !bus_rd_o && !bus_wr_o); // R9
endmodule

bind dma_edge_req_acceptor dreq_acceptor_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chan_off_i  (chan_off_i),
  .bus_break_i (bus_break_i),
  .xfer_end_i  (xfer_end_i),
  .req_held_o  (req_held_o),
  .activate_o  (activate_o),
  .accept_rdy_o(accept_rdy_o),
  .bus_rd_o    (bus_rd_o),
  .bus_wr_o    (bus_wr_o),
  .bus_rel_o   (bus_rel_o)
);

// File: tb/dma_edge_req_acceptor_tb.sv
module dma_edge_req_acceptor_tb;
  localparam time CLK_P = 20ns;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic chan_on_i = 1'b0, chan_off_i = 1'b0, dreq_ni = 1'b1;
  logic bus_break_i = 1'b1, xfer_end_i = 1'b0, rd_done_i = 1'b0, wr_done_i = 1'b0;
  logic req_held_o, activate_o, accept_rdy_o, bus_rd_o, bus_wr_o, bus_rel_o;

  int checks = 0, errors = 0, acts = 0;
  int rd_lat = 0, wr_lat = 0, rd_cnt = 0, wr_cnt = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  dma_edge_req_acceptor u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .chan_on_i(chan_on_i), .chan_off_i(chan_off_i),
    .dreq_ni(dreq_ni), .bus_break_i(bus_break_i), .xfer_end_i(xfer_end_i),
    .rd_done_i(rd_done_i), .wr_done_i(wr_done_i), .req_held_o(req_held_o),
    .activate_o(activate_o), .accept_rdy_o(accept_rdy_o), .bus_rd_o(bus_rd_o),
    .bus_wr_o(bus_wr_o), .bus_rel_o(bus_rel_o)
  );

  // bus model and activation counter, both at the falling edge
  always @(negedge clk_i) begin
    if (activate_o) acts++;
    if (bus_rd_o) begin rd_done_i = (rd_cnt >= rd_lat); rd_cnt++; end
    else begin rd_done_i = 1'b0; rd_cnt = 0; end
    if (bus_wr_o) begin wr_done_i = (wr_cnt >= wr_lat); wr_cnt++; end
    else begin wr_done_i = 1'b0; wr_cnt = 0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_on();
    chan_on_i = 1'b1; cyc(1); chan_on_i = 1'b0;
  endtask

  task automatic pulse_off();
    chan_off_i = 1'b1; cyc(1); chan_off_i = 1'b0;
  endtask

  // vectors: low_len, rd_lat, wr_lat, exp_acts, exp_rdy_at_end
  localparam int NV = 5;
  localparam int VEC [NV][5] = '{
    '{1,  0, 0, 1, 1},
    '{3,  2, 1, 1, 1},
    '{2,  0, 4, 1, 1},
    '{60, 1, 1, 1, 0},
    '{8,  3, 3, 1, 1}
  };

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a0;
    int seen;
    // R1: reset state
    cyc(3);
    chk({req_held_o, activate_o, accept_rdy_o, bus_rd_o, bus_wr_o, bus_rel_o} == 6'b0,
        "R1 reset", {req_held_o, activate_o, accept_rdy_o, bus_rd_o, bus_wr_o, bus_rel_o}, 0);
    rst_ni = 1'b1;
    cyc(2);
    // R2: pin low before enable is ignored
    dreq_ni = 1'b0;
    cyc(8);
    chk(!req_held_o && !accept_rdy_o && acts == 0, "R2 no enable", {req_held_o, accept_rdy_o}, 0);
    chk({req_held_o, activate_o, accept_rdy_o, bus_rd_o, bus_wr_o, bus_rel_o} == 6'b0,
        "R1 idle until enable", {req_held_o, accept_rdy_o}, 0);

    // vector table: R3 R5 R7 R10
    for (int v = 0; v < NV; v++) begin
      dreq_ni = 1'b1; bus_break_i = 1'b1;
      pulse_off(); cyc(4);
      rd_lat = VEC[v][1]; wr_lat = VEC[v][2];
      a0 = acts;
      pulse_on();
      dreq_ni = 1'b0; cyc(VEC[v][0]); dreq_ni = (VEC[v][0] >= 50) ? 1'b0 : 1'b1;
      cyc(50 - VEC[v][0] > 0 ? 50 - VEC[v][0] : 0);
      chk(acts - a0 == VEC[v][3], $sformatf("R10 vector %0d acts", v), acts - a0, VEC[v][3]);
      chk(accept_rdy_o == VEC[v][4][0], $sformatf("R7 vector %0d ready", v), accept_rdy_o, VEC[v][4]);
    end

    // exact enable timing with pin low and no bus break: R2 R3 R4
    dreq_ni = 1'b1; pulse_off(); cyc(4);
    dreq_ni = 1'b0; bus_break_i = 1'b0; cyc(4);
    rd_lat = 1; wr_lat = 6;
    a0 = acts;
    chan_on_i = 1'b1; cyc(1); chan_on_i = 1'b0;
    chk(accept_rdy_o && !req_held_o, "R2 ready after enable edge", {accept_rdy_o, req_held_o}, 2);
    cyc(1);
    chk(req_held_o && !accept_rdy_o, "R3 held next edge", {req_held_o, accept_rdy_o}, 2);
    cyc(5);
    chk(req_held_o && acts == a0, "R4 waits for break", acts - a0, 0);
    bus_break_i = 1'b1; cyc(1);
    chk(activate_o && !req_held_o && bus_rd_o, "R4 activation at break",
        {activate_o, req_held_o, bus_rd_o}, 5);
    cyc(1);
    chk(!activate_o && !accept_rdy_o, "R8 ready closed after activation", {activate_o, accept_rdy_o}, 0);
    seen = 0;
    for (int i = 0; i < 30 && !bus_rel_o; i++) begin
      if ((bus_rd_o || bus_wr_o) && accept_rdy_o) seen++;
      cyc(1);
    end
    chk(seen == 0, "R6 ready closed in read/write", seen, 0);
    chk(bus_rel_o, "R5 release reached", bus_rel_o, 1);
    cyc(1);
    chk(!bus_rel_o && !bus_rd_o && !bus_wr_o, "R5 release one cycle", {bus_rd_o, bus_wr_o, bus_rel_o}, 0);
    cyc(10);
    chk(acts - a0 == 1 && !accept_rdy_o, "R7 held low no second activation", acts - a0, 1);
    dreq_ni = 1'b1;
    seen = 0;
    for (int i = 0; i < 4; i++) begin cyc(1); if (accept_rdy_o) seen = 1; end
    chk(seen == 1, "R7 re-arm after high", seen, 1);

    // low-high-low toggle inside the write phase: R6 R10
    rd_lat = 0; wr_lat = 10;
    a0 = acts;
    dreq_ni = 1'b0;
    for (int i = 0; i < 20 && !bus_wr_o; i++) cyc(1);
    cyc(1);
    dreq_ni = 1'b1; cyc(3); dreq_ni = 1'b0; cyc(2);
    chk(bus_wr_o && !accept_rdy_o && acts - a0 == 1, "R6 no re-arm before write end",
        {bus_wr_o, accept_rdy_o}, 2);
    for (int i = 0; i < 20 && bus_wr_o; i++) cyc(1);
    cyc(8);
    chk(acts - a0 == 2, "R6 re-arm after write end", acts - a0, 2);
    cyc(40);
    chk(acts - a0 == 2, "R10 one activation per edge", acts - a0, 2);

    // transfer end and priority over enable: R9
    dreq_ni = 1'b1; wr_lat = 0; cyc(30);
    chk(accept_rdy_o, "R9 ready before end", accept_rdy_o, 1);
    xfer_end_i = 1'b1; cyc(1); xfer_end_i = 1'b0;
    chk(!accept_rdy_o && !req_held_o, "R9 end closes acceptance", accept_rdy_o, 0);
    a0 = acts;
    dreq_ni = 1'b0; cyc(2); dreq_ni = 1'b1; cyc(8);
    chk(acts == a0 && !req_held_o, "R9 no accept after end", acts - a0, 0);
    xfer_end_i = 1'b1; chan_on_i = 1'b1; cyc(1);
    xfer_end_i = 1'b0; chan_on_i = 1'b0;
    chk(!accept_rdy_o, "R9 end wins over enable", accept_rdy_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule